// File: doc/BRIEF.md
# Debug-Aware Low-Power Mode Controller

This block sequences a system between four power modes: run, very-low-power run (VLPR), stop and very-low-power stop (VLPS). Software requests a new mode with a one-cycle request strobe. A wakeup event brings the system out of a stop mode. The controller drives the core clock enable and a permission flag that lets a debugger reach system memory. It also reports the current mode.

Two request lines from the debug port show whether a debugger is attached: a debug power-up request and a system power-up request. The controller takes either line as the sign of an active debugger. It samples them only while the system is in one of the run modes. A debugger must be able to keep reaching the core registers. So while a debugger is active, a request for VLPS is quietly turned into stop, and the core clock stays on. A pseudo-stop status flag records that this demotion took place. Memory access through the system interconnect is blocked for the debugger in every stop mode.

Leaving a stop mode takes a fixed exit delay, set by a parameter with a default of 4 cycles. At the end of it the system returns to whichever run mode it left from.

Top module: `pmc_lp_ctrl`

## Requirements
- R1: After a synchronous reset, the mode is run (encoding 0), the core clock enable is 1, the debug memory permission is 1 and the pseudo-stop flag is 0.
- R2: Modes are encoded run=0, VLPR=1, stop=2, VLPS=3. In a run mode, a valid request for run, VLPR or stop takes effect on the mode output in the cycle after the request is sampled. A request for the mode already in force changes nothing.
- R3: The debugger counts as active when either the debug power-up request or the system power-up request is high. This is sampled on every clock edge while the current mode is run or VLPR.
- R4: A VLPS request with the debugger inactive enters VLPS with the core clock enable at 0.
- R5: A VLPS request from run with the debugger active enters stop (2) and sets the pseudo-stop flag.
- R6: A VLPS request from VLPR with the debugger active also enters stop (2) and sets the pseudo-stop flag.
- R7: On entry to any stop mode, the core clock enable is 1 if the debugger is active and 0 if it is not.
- R8: The debug memory permission is 1 in run and VLPR and 0 in stop and VLPS.
- R9: While in a stop mode, changes on the two debug request inputs are ignored: the core clock enable keeps its entry value until the return to a run mode.
- R10: A wakeup sampled in a stop mode returns the mode to the run mode it came from exactly 4 clock edges later. Mode requests and further wakeups are ignored in stop modes and during the exit.
- R11: The pseudo-stop flag clears on the return to a run mode. A wakeup seen in a run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode (0 run, 1 VLPR, 2 stop, 3 VLPS) |
| dbg_pwr_req | input | 1 | Debug power-up request from the debug port |
| sys_pwr_req | input | 1 | System power-up request from the debug port |
| wakeup | input | 1 | Wakeup event for leaving a stop mode |
| mode_o | output | 2 | Current power mode |
| core_clk_en_o | output | 1 | Core clock enable |
| dbg_mem_allow_o | output | 1 | Debugger may access system memory over the interconnect |
| pseudo_stop_o | output | 1 | A VLPS request was demoted to stop |

## Verification
On every cycle, the assertions check these invariants:
- Run modes always have the core clock enabled and memory access permitted.
- Stop modes never permit memory access.
- VLPS never runs the core clock.
- The pseudo-stop flag is only ever seen in stop.
- The clock enable stays steady across consecutive stop cycles.
- The exit timer ends its count cleanly.

Other behaviour can only be shown by the bench scenarios, which compare against a reference model on every clock:
- the exact four-edge exit latency;
- the return to the correct originating run mode;
- the demotion of VLPS to stop from both run and VLPR;
- debug-input changes being ignored during stop;
- wakeups and requests being ignored where they do not apply.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_VLPR = 2'd1,
    PM_STOP = 2'd2,
    PM_VLPS = 2'd3
  } pm_mode_e;

  function automatic logic pm_is_run(input pm_mode_e m);
    return (m == PM_RUN) || (m == PM_VLPR);
  endfunction
endpackage

// File: rtl/pmc_dbg_track.sv
module pmc_dbg_track (
  input  logic clk,
  input  logic rst,
  input  logic allow_upd,
  input  logic dbg_pwr_req,
  input  logic sys_pwr_req,
  output logic dbg_now,
  output logic dbg_q
);
  logic req_any;
  assign req_any = dbg_pwr_req | sys_pwr_req;
  // live view: fresh inputs in run modes, frozen copy otherwise
  assign dbg_now = allow_upd ? req_any : dbg_q;

  always_ff @(posedge clk) begin
    if (rst) dbg_q <= 1'b0;
    else     dbg_q <= dbg_now;
  end
endmodule

// File: rtl/pmc_exit_timer.sv
module pmc_exit_timer #(
  parameter int EXIT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(EXIT_CYC + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(EXIT_CYC - 1);
    end
  end

  p_done_ends_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_start_arms_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  logic [1:0] req_mode,
  input  logic     wakeup,
  input  logic     dbg_now,
  input  logic     exit_done,
  output pm_mode_e mode_q,
  output pm_mode_e mode_d,
  output logic     pseudo_q,
  output logic     pseudo_d,
  output logic     exit_start
);
  pm_mode_e origin_q, origin_d;

  always_comb begin
    mode_d     = mode_q;
    pseudo_d   = pseudo_q;
    origin_d   = origin_q;
    exit_start = 1'b0;
    if (pm_is_run(mode_q)) begin
      if (req_valid) begin
        unique case (pm_mode_e'(req_mode))
          PM_RUN:  mode_d = PM_RUN;
          PM_VLPR: mode_d = PM_VLPR;
          PM_STOP: begin
            mode_d   = PM_STOP;
            origin_d = mode_q;
          end
          PM_VLPS: begin
            origin_d = mode_q;
            if (dbg_now) begin
              mode_d   = PM_STOP;
              pseudo_d = 1'b1;
            end else begin
              mode_d   = PM_VLPS;
            end
          end
          default: mode_d = mode_q;
        endcase
      end
    end else begin
      exit_start = wakeup;
      if (exit_done) begin
        mode_d   = origin_q;
        pseudo_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_RUN;
      origin_q <= PM_RUN;
      pseudo_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      origin_q <= origin_d;
      pseudo_q <= pseudo_d;
    end
  end

  p_stop_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!pm_is_run(mode_q) && !exit_done) |=> (mode_q == $past(mode_q)));
  p_origin_run_r10: assert property (@(posedge clk) disable iff (rst)
    !pm_is_run(mode_q) |-> pm_is_run(origin_q));
endmodule

// File: rtl/pmc_lp_ctrl.sv
module pmc_lp_ctrl
  import pmc_pkg::*;
#(
  parameter int EXIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       dbg_pwr_req,
  input  logic       sys_pwr_req,
  input  logic       wakeup,
  output logic [1:0] mode_o,
  output logic       core_clk_en_o,
  output logic       dbg_mem_allow_o,
  output logic       pseudo_stop_o
);
  pm_mode_e mode_q, mode_d;
  logic     pseudo_q, pseudo_d;
  logic     dbg_now, dbg_q;
  logic     exit_start, exit_busy, exit_done;
  logic     clk_en_q, mem_allow_q;

  pmc_dbg_track u_dbg (
    .clk(clk), .rst(rst),
    .allow_upd(pm_is_run(mode_q)),
    .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req),
    .dbg_now(dbg_now), .dbg_q(dbg_q)
  );

  pmc_exit_timer #(.EXIT_CYC(EXIT_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .start(exit_start), .busy(exit_busy), .done(exit_done)
  );

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_mode(req_mode), .wakeup(wakeup),
    .dbg_now(dbg_now), .exit_done(exit_done),
    .mode_q(mode_q), .mode_d(mode_d),
    .pseudo_q(pseudo_q), .pseudo_d(pseudo_d),
    .exit_start(exit_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_q    <= 1'b1;
      mem_allow_q <= 1'b1;
    end else begin
      clk_en_q    <= pm_is_run(mode_d) | dbg_now;
      mem_allow_q <= pm_is_run(mode_d);
    end
  end

  assign mode_o          = mode_q;
  assign core_clk_en_o   = clk_en_q;
  assign dbg_mem_allow_o = mem_allow_q;
  assign pseudo_stop_o   = pseudo_q;

  p_run_clk_r7: assert property (@(posedge clk) disable iff (rst)
    pm_is_run(pm_mode_e'(mode_o)) |-> (core_clk_en_o && dbg_mem_allow_o));
  p_stop_no_mem_r8: assert property (@(posedge clk) disable iff (rst)
    !pm_is_run(pm_mode_e'(mode_o)) |-> !dbg_mem_allow_o);
  p_vlps_clk_off_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_VLPS) |-> !core_clk_en_o);
  p_pseudo_stop_r5: assert property (@(posedge clk) disable iff (rst)
    pseudo_stop_o |-> (mode_o == PM_STOP));
  p_clk_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!pm_is_run(pm_mode_e'(mode_o)) ##1 !pm_is_run(pm_mode_e'(mode_o)))
      |-> $stable(core_clk_en_o));
  p_dbg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!pm_is_run(mode_q) && exit_busy) |=> $stable(dbg_q));
endmodule

// File: tb/test_pmc_lp_ctrl.sv
module test_pmc_lp_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic       dbg_pwr_req = 1'b0;
  logic       sys_pwr_req = 1'b0;
  logic       wakeup = 1'b0;
  logic [1:0] mode_o;
  logic       core_clk_en_o, dbg_mem_allow_o, pseudo_stop_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  // reference model state
  int m_mode = 0, m_orig = 0, m_dbg = 0, m_pseudo = 0, m_cnt = -1;
  int m_clk = 1, m_mem = 1;

  always #2 clk = ~clk;

  pmc_lp_ctrl i_pmc_lp_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req), .wakeup(wakeup),
    .mode_o(mode_o), .core_clk_en_o(core_clk_en_o),
    .dbg_mem_allow_o(dbg_mem_allow_o), .pseudo_stop_o(pseudo_stop_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural model, advanced on every clock edge
  always @(posedge clk) begin
    int nm, np, dn;
    bit run;
    cyc++;
    if (rst) begin
      m_mode = 0; m_orig = 0; m_dbg = 0; m_pseudo = 0; m_cnt = -1;
      m_clk = 1; m_mem = 1;
    end else begin
      run = (m_mode < 2);
      dn  = run ? int'(dbg_pwr_req | sys_pwr_req) : m_dbg;
      nm  = m_mode;
      np  = m_pseudo;
      if (run) begin
        if (req_valid) begin
          if (req_mode < 2) nm = int'(req_mode);
          else begin
            m_orig = m_mode;
            if (req_mode == 2) nm = 2;
            else if (dn != 0) begin nm = 2; np = 1; end
            else nm = 3;
          end
        end
      end else begin
        if (m_cnt == 0) begin nm = m_orig; np = 0; m_cnt = -1; end
        else if (m_cnt > 0) m_cnt--;
        else if (wakeup) m_cnt = 3;
      end
      m_dbg = dn; m_mode = nm; m_pseudo = np;
      m_clk = (nm < 2 || dn != 0) ? 1 : 0;
      m_mem = (nm < 2) ? 1 : 0;
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 mode", int'(mode_o), m_mode);
      check("R7 core_clk_en", int'(core_clk_en_o), m_clk);
      check("R8 dbg_mem_allow", int'(dbg_mem_allow_o), m_mem);
      check("R5 pseudo_stop", int'(pseudo_stop_o), m_pseudo);
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [1:0] m);
    req_valid = 1'b1; req_mode = m;
    tick(1);
    req_valid = 1'b0;
  endtask

  // pulse wakeup, then verify the exact exit latency
  task automatic wake_and_check(input int exp_stop, input int exp_ret);
    wakeup = 1'b1;
    tick(1);
    wakeup = 1'b0;
    req_valid = 1'b1; req_mode = 2'd1;   // ignored during exit (R10)
    tick(2);
    req_valid = 1'b0;
    wakeup = 1'b1;                       // ignored while busy (R10)
    tick(1);
    wakeup = 1'b0;
    check("R10 still in stop", int'(mode_o), exp_stop);
    tick(1);
    check("R10 returned to origin", int'(mode_o), exp_ret);
    check("R11 pseudo cleared", int'(pseudo_stop_o), 0);
  endtask

  initial begin
    tick(3);
    check("R1 mode", int'(mode_o), 0);
    check("R1 clk_en", int'(core_clk_en_o), 1);
    check("R1 mem_allow", int'(dbg_mem_allow_o), 1);
    check("R1 pseudo", int'(pseudo_stop_o), 0);
    rst = 1'b0;
    tick(2);

    request(2'd1);
    check("R2 enter VLPR", int'(mode_o), 1);
    request(2'd1);
    check("R2 same-mode request", int'(mode_o), 1);
    request(2'd0);
    check("R2 back to run", int'(mode_o), 0);

    request(2'd3);
    check("R4 VLPS entered", int'(mode_o), 3);
    check("R4 clock off", int'(core_clk_en_o), 0);
    dbg_pwr_req = 1'b1;
    tick(2);
    check("R9 debug change ignored", int'(core_clk_en_o), 0);
    wake_and_check(3, 0);

    tick(1);
    request(2'd3);
    check("R5 demoted to stop", int'(mode_o), 2);
    check("R5 pseudo set", int'(pseudo_stop_o), 1);
    check("R7 clock kept", int'(core_clk_en_o), 1);
    check("R8 memory blocked", int'(dbg_mem_allow_o), 0);
    wake_and_check(2, 0);

    request(2'd1);
    dbg_pwr_req = 1'b0; sys_pwr_req = 1'b1;
    tick(1);
    request(2'd3);
    check("R6 demoted from VLPR", int'(mode_o), 2);
    check("R3 system request alone marks debug", int'(pseudo_stop_o), 1);
    sys_pwr_req = 1'b0;
    tick(3);
    check("R9 clock held after debug drop", int'(core_clk_en_o), 1);
    wake_and_check(2, 1);

    tick(1);
    request(2'd2);
    check("R7 stop without debug", int'(core_clk_en_o), 0);
    check("R7 no pseudo", int'(pseudo_stop_o), 0);
    wake_and_check(2, 1);

    wakeup = 1'b1;
    tick(3);
    wakeup = 1'b0;
    check("R11 wakeup in run ignored", int'(mode_o), 1);
    tick(2);
    finish_run();
  end
endmodule